// File: doc/BRIEF.md
# Register ALU with Carry Flag

This block is the arithmetic and logic stage of a small 8-bit register processor. Each cycle it receives two register operands (a first operand `opnd_a` and a second operand `opnd_b`), a 4-bit operation selector and an enable. It produces the result and the carry flag the operation would leave behind, both combinationally, in the same cycle. The only state is a one-bit carry/borrow flag. That flag feeds the chained add and subtract operations and is written on the clock edge when the enable is high.

Sixteen selector codes cover the following:
- add and subtract, each with or without the chained flag
- increment and decrement
- the bitwise logic operations
- complement
- single-bit shifts
- a register move

Single-operand operations use only `opnd_a`. Codes that are not assigned pass `opnd_a` through and leave the flag alone. Only the additive operations and the shifts write the flag.

Top module: `carry_alu`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears the stored carry flag `carry_q` to 0.
- R2: Code 0000 (move) returns `opnd_b`. The unassigned codes 0101, 1110 and 1111 return `opnd_a`. All four of these codes leave the carry flag unchanged.
- R3: Code 0001 returns `opnd_a + opnd_b` and code 0010 returns `opnd_a + opnd_b + carry_q`. Each result is taken modulo 256, and the carry-out of bit 7 is the new flag.
- R4: Code 0100 returns `opnd_a - opnd_b` and code 0011 returns `opnd_a - opnd_b - carry_q`. Each result is taken modulo 256. The new flag is the borrow-out: 1 exactly when the true difference is negative.
- R5: Code 0110 returns `opnd_a + 1` and code 0111 returns `opnd_a - 1`. Both results are taken modulo 256. The new flag is 1 only on wrap-around: 0xFF to 0x00 for increment, 0x00 to 0xFF for decrement.
- R6: The following codes leave the carry flag unchanged:

  | Code | Operation | Result |
  |------|-----------|--------|
  | 1000 | complement | `~opnd_a` |
  | 1001 | AND | `opnd_a & opnd_b` |
  | 1010 | OR | `opnd_a \| opnd_b` |
  | 1011 | XOR | `opnd_a ^ opnd_b` |

- R7: Code 1100 shifts `opnd_a` right by one and code 1101 shifts it left by one. The vacated bit is filled with 0, and the bit shifted out (bit 0 for a right shift, bit 7 for a left shift) becomes the new flag.
- R8: `carry_q` takes the value of `carry_next` on a rising clock edge when `op_en` is 1, and holds its value when `op_en` is 0.
- R9: `result` and `carry_next` depend only on the current inputs and `carry_q`, and are valid in the same cycle the inputs are applied. For operations that do not write the flag, `carry_next` equals `carry_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Commit the operation's flag on this edge |
| op_code | input | 4 | Operation selector |
| opnd_a | input | 8 | First operand, also the only operand of single-operand codes |
| opnd_b | input | 8 | Second operand |
| result | output | 8 | Operation result, combinational |
| carry_next | output | 1 | Flag value the operation would store |
| carry_q | output | 1 | Stored carry/borrow flag |

## Verification
The assertions assume that `op_code`, the operands and `op_en` are stable across each rising edge and carry known values whenever reset is released. The flag checks compare against values sampled at the previous edge, so they also assume inputs change only between edges. The stimulus meets this by driving every input on the falling edge and holding it through the next rising edge. It also sets the stored flag to a known 0 or 1 before each chained or flag-preserving operation, so both values of the incoming flag are seen.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SBB  = 4'd3,
        OP_SUB  = 4'd4,
        OP_RSV5 = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_CPL  = 4'd8,
        OP_AND  = 4'd9,
        OP_OR   = 4'd10,
        OP_XOR  = 4'd11,
        OP_SHR  = 4'd12,
        OP_SHL  = 4'd13,
        OP_RSVE = 4'd14,
        OP_RSVF = 4'd15
    } alu_op_e;

    // Control word produced by the decoder
    typedef struct packed {
        logic arith;     // result comes from the adder
        logic y_one;     // adder second input is the constant one
        logic sub;       // adder subtracts, flag is borrow
        logic chain;     // stored flag feeds the adder
        logic wr_carry;  // operation writes the flag
    } alu_ctl_t;

    typedef struct packed {
        logic carry;
    } alu_state_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import carry_alu_pkg::*;
(
    input  logic [3:0] op_code,
    output alu_ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        case (alu_op_e'(op_code))
            OP_ADD: begin ctl.arith = 1'b1; ctl.wr_carry = 1'b1; end
            OP_ADC: begin ctl.arith = 1'b1; ctl.chain = 1'b1; ctl.wr_carry = 1'b1; end
            OP_SUB: begin ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.wr_carry = 1'b1; end
            OP_SBB: begin
                ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.chain = 1'b1; ctl.wr_carry = 1'b1;
            end
            OP_INC: begin ctl.arith = 1'b1; ctl.y_one = 1'b1; ctl.wr_carry = 1'b1; end
            OP_DEC: begin
                ctl.arith = 1'b1; ctl.y_one = 1'b1; ctl.sub = 1'b1; ctl.wr_carry = 1'b1;
            end
            OP_SHR, OP_SHL: ctl.wr_carry = 1'b1;
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         y_one,
    input  logic         sub,
    input  logic         chain,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         flag
);

    localparam int WX = W + 1;

    logic [W-1:0] y;
    logic [W-1:0] y_x;
    logic         c_eff;
    logic         c_raw;
    logic         c_out;

    always_comb begin
        y     = y_one ? W'(1) : b;
        y_x   = sub ? ~y : y;
        c_eff = chain ? cin : 1'b0;
        // In subtract mode a borrow-in maps to a missing +1
        c_raw = sub ? ~c_eff : c_eff;
        {c_out, sum} = {1'b0, a} + {1'b0, y_x} + WX'(c_raw);
        flag  = sub ? ~c_out : c_out;
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import carry_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op_code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         shift_out
);

    always_comb begin
        shift_out = 1'b0;
        case (alu_op_e'(op_code))
            OP_MOV: res = b;
            OP_CPL: res = ~a;
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHR: begin
                res       = {1'b0, a[W-1:1]};
                shift_out = a[0];
            end
            OP_SHL: begin
                res       = {a[W-2:0], 1'b0};
                shift_out = a[W-1];
            end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/carry_alu.sv
module carry_alu
    import carry_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_en,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         carry_next,
    output logic         carry_q
);

    alu_ctl_t     ctl;
    alu_state_t   state_d, state_q;
    logic [W-1:0] arith_sum;
    logic         arith_flag;
    logic [W-1:0] logic_res;
    logic         shift_bit;

    alu_op_decode u_dec (
        .op_code (op_code),
        .ctl     (ctl)
    );

    alu_addsub #(.W(W)) u_add (
        .a     (opnd_a),
        .b     (opnd_b),
        .y_one (ctl.y_one),
        .sub   (ctl.sub),
        .chain (ctl.chain),
        .cin   (state_q.carry),
        .sum   (arith_sum),
        .flag  (arith_flag)
    );

    alu_logic #(.W(W)) u_log (
        .op_code   (op_code),
        .a         (opnd_a),
        .b         (opnd_b),
        .res       (logic_res),
        .shift_out (shift_bit)
    );

    always_comb begin
        state_d    = state_q;
        result     = ctl.arith ? arith_sum : logic_res;
        carry_next = state_q.carry;
        if (ctl.wr_carry) begin
            carry_next = ctl.arith ? arith_flag : shift_bit;
        end
        if (op_en) begin
            state_d.carry = carry_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign carry_q = state_q.carry;

endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_en,
    input logic [3:0]   op_code,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         carry_next,
    input logic         carry_q
);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(carry_q));

    // R8
    commit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_en |=> carry_q == $past(carry_next));

    // R6
    logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_code inside {4'b1000, 4'b1001, 4'b1010, 4'b1011}))
        |=> $stable(carry_q));

    // R2
    spare_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && (op_code inside {4'b0000, 4'b0101, 4'b1110, 4'b1111}))
        |=> $stable(carry_q));

    // R2
    move_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'b0000) |-> (result == opnd_b));

    // R3
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'b0001) |-> ({carry_next, result} == ({1'b0, opnd_a} + {1'b0, opnd_b})));

    // R7
    shr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 4'b1100) |=> (carry_q == $past(opnd_a[0])));

    // R7
    shl_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_code == 4'b1101) |=> (carry_q == $past(opnd_a[W-1])));

endmodule

bind carry_alu carry_alu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_en      (op_en),
    .op_code    (op_code),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .result     (result),
    .carry_next (carry_next),
    .carry_q    (carry_q)
);

// File: tb/carry_alu_bench.sv
`timescale 1ns/1ps
module carry_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic [7:0] result;
    logic       carry_next;
    logic       carry_q;

    int checks = 0;
    int errors = 0;
    logic mc = 1'b0;   // bench copy of the stored flag

    always #2.5 clk = ~clk;

    carry_alu u_carry_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_en      (op_en),
        .op_code    (op_code),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .result     (result),
        .carry_next (carry_next),
        .carry_q    (carry_q)
    );

    // Expected {flag, result} from the requirement text
    function automatic logic [8:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic c);
        logic [8:0] t;
        case (op)
            4'd0:  t = {c, b};
            4'd1:  t = {1'b0, a} + {1'b0, b};
            4'd2:  t = {1'b0, a} + {1'b0, b} + {8'd0, c};
            4'd3:  t = {1'b0, a} - {1'b0, b} - {8'd0, c};
            4'd4:  t = {1'b0, a} - {1'b0, b};
            4'd6:  t = {1'b0, a} + 9'd1;
            4'd7:  t = {1'b0, a} - 9'd1;
            4'd8:  t = {c, ~a};
            4'd9:  t = {c, a & b};
            4'd10: t = {c, a | b};
            4'd11: t = {c, a ^ b};
            4'd12: t = {a[0], 1'b0, a[7:1]};
            4'd13: t = {a[7], a[6:0], 1'b0};
            default: t = {c, a};
        endcase
        return t;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic en);
        logic [8:0] e;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; op_en = en;
        #1;
        e = model(op, a, b, mc);
        check(req, {1'b0, result}, {1'b0, e[7:0]});
        check("R9", {8'd0, carry_next}, {8'd0, e[8]});
        @(posedge clk);
        #1;
        if (en) mc = e[8];
        check("R8", {8'd0, carry_q}, {8'd0, mc});
    endtask

    task automatic set_flag(input logic v);
        // 0xFF + 1 sets the flag, 0 + 0 clears it
        step("R3", 4'd1, v ? 8'hFF : 8'h00, v ? 8'h01 : 8'h00, 1'b1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        mc = 1'b0;
        check("R1", {8'd0, carry_q}, 9'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_move_spare;
        set_flag(1'b1);
        step("R2", 4'd0, 8'h12, 8'hA5, 1'b1);
        step("R2", 4'd5, 8'h3C, 8'hFF, 1'b1);
        step("R2", 4'd14, 8'h81, 8'h00, 1'b1);
        step("R2", 4'd15, 8'h7E, 8'h55, 1'b1);
        set_flag(1'b0);
        step("R2", 4'd15, 8'hFF, 8'hFF, 1'b1);
    endtask

    task automatic t_add;
        step("R3", 4'd1, 8'h3A, 8'h45, 1'b1);
        step("R3", 4'd1, 8'hF0, 8'h20, 1'b1);
        step("R3", 4'd2, 8'hFF, 8'h00, 1'b1);   // flag 1 in: wraps to 00
        step("R3", 4'd2, 8'h10, 8'h01, 1'b1);
        step("R3", 4'd2, 8'h80, 8'h80, 1'b1);
    endtask

    task automatic t_sub;
        set_flag(1'b0);
        step("R4", 4'd4, 8'h50, 8'h20, 1'b1);
        step("R4", 4'd4, 8'h05, 8'h06, 1'b1);   // borrow out
        step("R4", 4'd3, 8'h00, 8'h00, 1'b1);   // borrow in: FF, borrow
        step("R4", 4'd3, 8'h10, 8'h0F, 1'b1);   // 10-0F-1 = 0, no borrow
        step("R4", 4'd4, 8'h42, 8'h42, 1'b1);
    endtask

    task automatic t_incdec;
        step("R5", 4'd6, 8'h7F, 8'h00, 1'b1);
        step("R5", 4'd6, 8'hFF, 8'h33, 1'b1);
        step("R5", 4'd7, 8'h00, 8'h00, 1'b1);
        step("R5", 4'd7, 8'h01, 8'h99, 1'b1);
    endtask

    task automatic t_logic;
        for (int k = 0; k < 2; k++) begin
            set_flag(k[0]);
            step("R6", 4'd8, 8'h5A, 8'h00, 1'b1);
            step("R6", 4'd9, 8'hCC, 8'hAA, 1'b1);
            step("R6", 4'd10, 8'hCC, 8'hAA, 1'b1);
            step("R6", 4'd11, 8'hCC, 8'hAA, 1'b1);
        end
    endtask

    task automatic t_shift;
        step("R7", 4'd12, 8'h81, 8'h00, 1'b1);
        step("R7", 4'd12, 8'h02, 8'h00, 1'b1);
        step("R7", 4'd13, 8'h81, 8'h00, 1'b1);
        step("R7", 4'd13, 8'h40, 8'h00, 1'b1);
    endtask

    task automatic t_enable;
        set_flag(1'b0);
        step("R8", 4'd1, 8'hFF, 8'hFF, 1'b0);   // would carry, not committed
        step("R8", 4'd13, 8'h80, 8'h00, 1'b0);
        set_flag(1'b1);
        step("R8", 4'd4, 8'h09, 8'h01, 1'b0);   // would clear, not committed
        step("R8", 4'd12, 8'h00, 8'h00, 1'b1);  // committed: clears
        set_flag(1'b1);
        t_reset();                              // reset clears a set flag
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_move_spare();
        t_add();
        t_sub();
        t_incdec();
        t_logic();
        t_shift();
        t_enable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule